// File: doc/BRIEF.md
# Way-Predicting Two-Way Cache Lookup

This block is the tag-check and data-select stage of a small two-way set-associative cache. Each set carries one predictor bit that names the way expected to hit on the next access to that set. An accepted request compares only the predicted way's tag in its first cycle. The data multiplexer is already steered to that way, so the data read runs alongside the single compare. When the guess is right the response is a fast hit. When it is wrong the other way is compared in the next cycle. That second compare either finds the line, giving a way-miss hit and retraining the predictor, or finds nothing, giving a miss.

Lines are installed through a fill port. The fill picks its own victim way and points the set's predictor at the way it wrote. The block does no refill sequencing, no writes from the request side and no coherence. A miss only reports the outcome and returns zero data. Addresses select one line each: the low `SET_W` bits choose the set and the rest form the tag.

Top module: `wpred_cache_lookup`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `rsp_valid` is 0 and `rsp_class` is 0. All lines are invalid, so any first lookup is a miss.
- R2: A request is accepted on a rising edge with `req_valid` and `req_ready` both 1. If the predicted way of its set holds a valid line with the same tag, the response appears after the second rising edge from acceptance. It carries `rsp_class` = 1, `rsp_hit` = 1 and that line's data.
- R3: If the predicted way does not match but the other way holds the tag, the response appears after the third rising edge from acceptance. It carries `rsp_class` = 2, `rsp_hit` = 1 and the line's data.
- R4: If neither way holds the tag, the response appears after the third rising edge from acceptance. It carries `rsp_class` = 3, `rsp_hit` = 0 and data 0.
- R5: In the cycle after accepting a request whose predicted-way compare fails, `req_ready` is 0 and the second compare runs. In the cycle after accepting a fast hit, `req_ready` stays 1.
- R6: After a way-miss hit, the set's predictor names the way that hit, so an immediate repeat of the same address is a fast hit.
- R7: A miss or a fast hit leaves the set's predictor unchanged.
- R8: A fill writes the way already holding the same tag, if there is one. Otherwise it writes the lowest-numbered invalid way (way 0 before way 1). If both ways are valid, it writes the way the predictor does not name. The fill then points the set's predictor at the way written.
- R9: Fast hits may be accepted on consecutive edges. Their responses then appear on consecutive cycles, in order.
- R10: Whenever `rsp_valid` is 0, `rsp_class` is 0 and `rsp_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Lookup address: {tag, set} |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | DATA_W | Line data on a hit, 0 on a miss |
| rsp_hit | output | 1 | 1 on either kind of hit |
| rsp_class | output | 2 | 0 none, 1 fast hit, 2 way-miss hit, 3 miss |
| fill_valid | input | 1 | Install a line this cycle |
| fill_addr | input | ADDR_W | Address of the installed line |
| fill_data | input | DATA_W | Data of the installed line |

## Verification
The lookup is tried against an empty set, a line sitting in the predicted way, a line sitting in the other way, and a tag that neither way holds. These four patterns separate the three outcome codes and their two latencies, and they show whether `req_ready` drops only when the first compare fails. Repeats after a way-miss hit and after a miss show whether the predictor retrains only on the right event. A fill into a full set, followed by lookups of the evicted tag and the new tag, exposes the victim choice. A rewrite of a resident tag checks that a fill overwrites in place. Two back-to-back fast hits check pipelining. A long pseudo-random mix of fills and lookups is then compared against a reference model of lines and predictors. The bench counts how often the prediction was right.

// File: rtl/wpred_pkg.sv
package wpred_pkg;

  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_FAST = 2'd1,
    OUT_SLOW = 2'd2,
    OUT_MISS = 2'd3
  } outcome_e;

  // Victim: resident tag first, then first empty way, then the unpredicted way.
  function automatic logic pick_victim(input logic [WAYS-1:0] vld,
                                       input logic [WAYS-1:0] same,
                                       input logic            pred);
    logic way;
    if (same[0])      way = 1'b0;
    else if (same[1]) way = 1'b1;
    else if (!vld[0]) way = 1'b0;
    else if (!vld[1]) way = 1'b1;
    else              way = ~pred;
    return way;
  endfunction

endpackage

// File: rtl/wpred_tag_array.sv
module wpred_tag_array
  import wpred_pkg::*;
#(
  parameter int SET_W = 3,
  parameter int TAG_W = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SET_W-1:0]            lk_set,
  input  logic                        lk_way,
  output logic [TAG_W-1:0]            lk_tag,
  output logic                        lk_vld,
  input  logic [SET_W-1:0]            fl_set,
  output logic [WAYS-1:0]             fl_vld,
  output logic [WAYS-1:0][TAG_W-1:0]  fl_tag,
  input  logic                        wr_en,
  input  logic                        wr_way,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [TAG_W-1:0]            wr_tag
);

  localparam int SETS = 1 << SET_W;

  logic [TAG_W-1:0] tag_q [WAYS][SETS];
  logic [SETS-1:0]  vld_q [WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '{default: '0};
    end else if (wr_en) begin
      vld_q[wr_way][wr_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_way][wr_set] <= wr_tag;
  end

  // single compare port: one way of one set
  assign lk_tag = tag_q[lk_way][lk_set];
  assign lk_vld = vld_q[lk_way][lk_set];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      fl_tag[w] = tag_q[w][fl_set];
      fl_vld[w] = vld_q[w][fl_set];
    end
  end

endmodule

// File: rtl/wpred_data_array.sv
module wpred_data_array
  import wpred_pkg::*;
#(
  parameter int SET_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  rd_set,
  input  logic              rd_way,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int SETS = 1 << SET_W;

  logic [DATA_W-1:0] bank_out [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_bank
    logic [DATA_W-1:0] mem [SETS];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w))) mem[wr_set] <= wr_data;
    end
    assign bank_out[w] = mem[rd_set];
  end

  // output mux steered by the way select, ahead of the tag result
  assign rd_data = bank_out[rd_way];

endmodule

// File: rtl/wpred_way_predictor.sv
module wpred_way_predictor #(
  parameter int SET_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_a_set,
  output logic             rd_a_way,
  input  logic [SET_W-1:0] rd_b_set,
  output logic             rd_b_way,
  input  logic             train_en,
  input  logic [SET_W-1:0] train_set,
  input  logic             train_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic             fill_way
);

  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] pred_q;

  // a fill in the same cycle overrides training (later assignment wins)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_q <= '0;
    end else begin
      if (train_en) pred_q[train_set] <= train_way;
      if (fill_en)  pred_q[fill_set]  <= fill_way;
    end
  end

  assign rd_a_way = pred_q[rd_a_set];
  assign rd_b_way = pred_q[rd_b_set];

endmodule

// File: rtl/wpred_cache_lookup.sv
module wpred_cache_lookup
  import wpred_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SET_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic [1:0]        rsp_class,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data
);

  localparam int TAG_W = ADDR_W - SET_W;

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[SET_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SET_W];
  endfunction

  // stage registers
  logic              s1_valid, s2_valid;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic              s2_way;

  // shared compare port
  logic [SET_W-1:0]  lk_set;
  logic [TAG_W-1:0]  lk_want;
  logic              lk_way;
  logic [TAG_W-1:0]  lk_tag;
  logic              lk_vld;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;
  logic              s1_pred;

  // named events for the checker
  logic ev_fast, ev_wayfail, ev_slow, ev_miss, accept;

  // fill path
  logic [SET_W-1:0]             fl_set;
  logic [TAG_W-1:0]             fl_want;
  logic [WAYS-1:0]              fl_vld;
  logic [WAYS-1:0][TAG_W-1:0]   fl_tag;
  logic [WAYS-1:0]              fl_same;
  logic                         fl_pred;
  logic                         fl_way;

  // S1 and S2 are never both occupied, so one compare port serves both
  assign lk_set  = s2_valid ? set_of(s2_addr) : set_of(s1_addr);
  assign lk_want = s2_valid ? tag_of(s2_addr) : tag_of(s1_addr);
  assign lk_way  = s2_valid ? s2_way : s1_pred;
  assign lk_hit  = lk_vld && (lk_tag == lk_want);

  assign ev_fast    = s1_valid && !s2_valid && lk_hit;
  assign ev_wayfail = s1_valid && !s2_valid && !lk_hit;
  assign ev_slow    = s2_valid && lk_hit;
  assign ev_miss    = s2_valid && !lk_hit;

  assign req_ready = !ev_wayfail;
  assign accept    = req_valid && req_ready;

  assign fl_set  = set_of(fill_addr);
  assign fl_want = tag_of(fill_addr);

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      fl_same[w] = fl_vld[w] && (fl_tag[w] == fl_want);
    end
  end

  assign fl_way = pick_victim(fl_vld, fl_same, fl_pred);

  wpred_tag_array #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .lk_set (lk_set),
    .lk_way (lk_way),
    .lk_tag (lk_tag),
    .lk_vld (lk_vld),
    .fl_set (fl_set),
    .fl_vld (fl_vld),
    .fl_tag (fl_tag),
    .wr_en  (fill_valid),
    .wr_way (fl_way),
    .wr_set (fl_set),
    .wr_tag (fl_want)
  );

  wpred_data_array #(.SET_W(SET_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_set  (lk_set),
    .rd_way  (lk_way),
    .rd_data (lk_data),
    .wr_en   (fill_valid),
    .wr_way  (fl_way),
    .wr_set  (fl_set),
    .wr_data (fill_data)
  );

  wpred_way_predictor #(.SET_W(SET_W)) u_pred (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_set  (set_of(s1_addr)),
    .rd_a_way  (s1_pred),
    .rd_b_set  (fl_set),
    .rd_b_way  (fl_pred),
    .train_en  (ev_slow),
    .train_set (set_of(s2_addr)),
    .train_way (s2_way),
    .fill_en   (fill_valid),
    .fill_set  (fl_set),
    .fill_way  (fl_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s1_addr  <= '0;
      s2_addr  <= '0;
      s2_way   <= 1'b0;
    end else begin
      s1_valid <= accept;
      if (accept) s1_addr <= req_addr;
      s2_valid <= ev_wayfail;
      if (ev_wayfail) begin
        s2_addr <= s1_addr;
        s2_way  <= ~s1_pred;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_class <= OUT_NONE;
      rsp_data  <= '0;
    end else if (ev_fast) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= 1'b1;
      rsp_class <= OUT_FAST;
      rsp_data  <= lk_data;
    end else if (ev_slow) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= 1'b1;
      rsp_class <= OUT_SLOW;
      rsp_data  <= lk_data;
    end else if (ev_miss) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= 1'b0;
      rsp_class <= OUT_MISS;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_class <= OUT_NONE;
      rsp_data  <= '0;
    end
  end

endmodule

// File: rtl/wpred_cache_lookup_chk.sv
module wpred_cache_lookup_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [1:0]        rsp_class,
  input logic [DATA_W-1:0] rsp_data,
  input logic              s1_valid,
  input logic              s2_valid,
  input logic              ev_wayfail
);

  // R2: a fast hit answers two edges after its acceptance
  p_fast_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_class == 2'd1) |-> $past(req_valid && req_ready, 2));

  // R2, R3: every hit code carries the hit flag
  p_hit_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_class != 2'd3) |-> rsp_hit);

  // R3: a way-miss hit answers three edges after acceptance
  p_slow_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_class == 2'd2) |-> $past(req_valid && req_ready, 3));

  // R4: a miss answers late, without hit flag and with zero data
  p_miss_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_class == 2'd3) |->
      ($past(req_valid && req_ready, 3) && !rsp_hit && rsp_data == '0));

  // R5: a failed first compare is followed by the second compare, alone
  p_second_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wayfail |=> (s2_valid && !s1_valid));

  // R9: at most one request is under compare at any time
  p_single_stage_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid || !rsp_valid |-> $onehot0({s1_valid, s2_valid}));

  // R10: an idle response port reports no outcome
  p_idle_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_class == 2'd0 && !rsp_hit));

endmodule

bind wpred_cache_lookup wpred_cache_lookup_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_class  (rsp_class),
  .rsp_data   (rsp_data),
  .s1_valid   (s1_valid),
  .s2_valid   (s2_valid),
  .ev_wayfail (ev_wayfail)
);

// File: tb/wpred_cache_lookup_test.sv
module wpred_cache_lookup_test;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SET_W  = 3;
  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int SETS   = 1 << SET_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_ready;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_hit;
  logic [1:0]        rsp_class;
  logic              fill_valid;
  logic [ADDR_W-1:0] fill_addr;
  logic [DATA_W-1:0] fill_data;

  always #4 clk = ~clk;

  wpred_cache_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .rsp_class(rsp_class),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data)
  );

  // reference model of lines and predictors
  logic              m_vld  [SETS][2];
  logic [TAG_W-1:0]  m_tag  [SETS][2];
  logic [DATA_W-1:0] m_dat  [SETS][2];
  logic              m_pred [SETS];

  int n_chk = 0, n_bad = 0, n_right = 0, n_look = 0;
  int unsigned seed = 32'h1357_2468;
  logic [DATA_W-1:0] stamp = 32'h0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(input int s, input int k);
    logic [TAG_W-1:0] t;
    t = TAG_W'(k * 37 + s * 5 + 1);
    return {t, SET_W'(s)};
  endfunction

  task automatic model_fill(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    int s; logic [TAG_W-1:0] t; logic w;
    s = int'(a[SET_W-1:0]);
    t = a[ADDR_W-1:SET_W];
    if (m_vld[s][0] && m_tag[s][0] == t)      w = 1'b0;
    else if (m_vld[s][1] && m_tag[s][1] == t) w = 1'b1;
    else if (!m_vld[s][0])                    w = 1'b0;
    else if (!m_vld[s][1])                    w = 1'b1;
    else                                      w = ~m_pred[s];
    m_vld[s][w] = 1'b1;
    m_tag[s][w] = t;
    m_dat[s][w] = d;
    m_pred[s]   = w;
  endtask

  task automatic model_look(input logic [ADDR_W-1:0] a, output int cls,
                            output logic [DATA_W-1:0] d);
    int s; logic [TAG_W-1:0] t; logic p;
    s = int'(a[SET_W-1:0]);
    t = a[ADDR_W-1:SET_W];
    p = m_pred[s];
    if (m_vld[s][p] && m_tag[s][p] == t) begin
      cls = 1; d = m_dat[s][p];
    end else if (m_vld[s][~p] && m_tag[s][~p] == t) begin
      cls = 2; d = m_dat[s][~p]; m_pred[s] = ~p;
    end else begin
      cls = 3; d = '0;
    end
  endtask

  task automatic do_fill(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    stamp      = stamp + 32'h0001_0003;
    fill_valid = 1'b1;
    fill_addr  = a;
    fill_data  = stamp ^ {20'hA5C3E, a};
    model_fill(a, fill_data);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_look(input logic [ADDR_W-1:0] a, output int got);
    int ecls; int n; logic [DATA_W-1:0] edat; string lbl;
    model_look(a, ecls, edat);
    lbl = (ecls == 1) ? "R2" : (ecls == 2) ? "R3" : "R4";
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == (ecls == 1), "R5", "ready after accept", req_ready, ecls == 1);
    check(!rsp_valid && rsp_class == 2'd0 && !rsp_hit, "R10", "idle response code",
          {rsp_valid, rsp_hit, rsp_class}, 0);
    n = 1;
    while (!rsp_valid && n < 5) begin
      @(negedge clk);
      n++;
    end
    check(n == ((ecls == 1) ? 2 : 3), lbl, "latency", n, (ecls == 1) ? 2 : 3);
    check(rsp_class == 2'(ecls), lbl, "class", rsp_class, ecls);
    check(rsp_hit == (ecls != 3), lbl, "hit flag", rsp_hit, ecls != 3);
    check(rsp_data == edat, lbl, "data", rsp_data, edat);
    got = rsp_valid ? int'(rsp_class) : 0;
    n_look++;
    if (got == 1) n_right++;
  endtask

  task automatic expect_look(input logic [ADDR_W-1:0] a, input int want, input string req);
    int got;
    do_look(a, got);
    check(got == want, req, "outcome", got, want);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int got;
    for (int s = 0; s < SETS; s++) begin
      m_pred[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        m_vld[s][w] = 1'b0; m_tag[s][w] = '0; m_dat[s][w] = '0;
      end
    end
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    fill_valid = 1'b0; fill_addr = '0; fill_data = '0;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && rsp_class == 2'd0, "R1", "state in reset",
          {req_ready, rsp_valid, rsp_class}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid && rsp_class == 2'd0, "R1", "state after reset",
          {req_ready, rsp_valid, rsp_class}, 4'b1000);

    for (int s = 0; s < SETS; s++) begin
      expect_look(mk_addr(s, 0), 3, "R1");        // empty set misses
      do_fill(mk_addr(s, 0));                     // way 0
      do_fill(mk_addr(s, 1));                     // way 1, predictor -> 1
      expect_look(mk_addr(s, 1), 1, "R8");        // fill trained predictor
      expect_look(mk_addr(s, 0), 2, "R3");        // other way
      expect_look(mk_addr(s, 0), 1, "R6");        // retrained
      expect_look(mk_addr(s, 3), 3, "R4");        // absent tag
      expect_look(mk_addr(s, 0), 1, "R7");        // miss kept predictor
      expect_look(mk_addr(s, 0), 1, "R7");        // fast hit kept predictor
      do_fill(mk_addr(s, 2));                     // full set: evicts way 1
      expect_look(mk_addr(s, 2), 1, "R8");
      expect_look(mk_addr(s, 1), 3, "R8");        // evicted tag gone
      expect_look(mk_addr(s, 0), 2, "R8");        // survivor in way 0
      do_fill(mk_addr(s, 0));                     // overwrite in place
      expect_look(mk_addr(s, 0), 1, "R8");
      expect_look(mk_addr(s, 2), 2, "R8");
    end

    // R9: two fast hits on consecutive edges
    begin
      int c1, c2; logic [DATA_W-1:0] d1, d2;
      model_look(mk_addr(3, 2), c1, d1);
      model_look(mk_addr(3, 2), c2, d2);
      @(negedge clk);
      req_valid = 1'b1; req_addr = mk_addr(3, 2);
      @(negedge clk);
      check(req_ready, "R9", "ready for second request", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid && rsp_class == 2'd1 && rsp_data == d1, "R9", "first response",
            {rsp_valid, rsp_class}, 3'b101);
      @(negedge clk);
      check(rsp_valid && rsp_class == 2'd1 && rsp_data == d2, "R9", "second response",
            {rsp_valid, rsp_class}, 3'b101);
    end

    // pseudo-random mix against the model
    for (int i = 0; i < 400; i++) begin
      int s, k;
      seed = seed * 32'd1103515245 + 32'd12345;
      s = int'((seed >> 8) % SETS);
      k = int'((seed >> 16) % 4);
      if (((seed >> 24) % 5) == 0 && k < 3) do_fill(mk_addr(s, k));
      else do_look(mk_addr(s, k), got);
    end

    $display("predictions right: %0d of %0d lookups", n_right, n_look);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule